// File: doc/BRIEF.md
# Pipelined Bitmap Pixel Address Generator

This block turns X/Y pixel commands from a drawing engine into memory locations inside a packed bitmap. Two raster descriptions are held at its inputs, one for the destination surface and one for the source surface. Each description has a base byte address, a raster width in pixels and a colour depth of 1, 2, 4, 8 or 16 bits per pixel. A copy command is located in the source surface. Every other command is located in the destination surface.

For each accepted command the block forms the linear pixel index `y * width + x` and converts it to a byte offset inside 16-bit words. At low colour depths several pixels share one word, so the index is scaled down by a depth-dependent shift. The low four bits of the index are kept as a sub-word pixel position, which lets the downstream pixel writer find the pixel inside the word. The result is a packed command word holding the function code, the colour, the depth code, the sub-word position and a word-aligned 20-bit byte address.

The work is split over two register stages. The first stage forms the index and the second applies the shift and the base address. This keeps the multiplier and the adder in separate clock periods. The command fields travel beside the arithmetic so that they leave the block together with their address. The block accepts one command per clock and produces each result exactly two clocks later.

Top module: `pixel_addr_pipe`

## Requirements
- R1: A command with function code 6 (copy) is located with the source base, width and depth code. Every other function code uses the destination settings. The index is `y * width + x`.
- R2: Bit 0 of the output address is always 0.
- R3: The depth code holds depth minus one. Code 0 shifts by 4, code 1 by 3, code 3 by 2, code 7 by 1 and code 15 by 0. The byte offset is `(index << 1) >> shift`, truncated to the address width.
- R4: Any depth code other than 0, 1, 3 or 7 uses a shift of 0, the same as 16 bits per pixel.
- R5: The address is the low 20 bits of (selected base + offset), with bit 0 then cleared. Carries beyond bit 19 are dropped.
- R6: `out_valid` is high exactly two clocks after each clock in which `in_valid` is high. Back-to-back commands give back-to-back results in order. The settings used are the ones present in the clock the command was accepted.
- R7: The output word carries the function in bits 39:36, the colour in 35:28, the depth code in 27:24, the sub-word position in 23:20 and the address in 19:0. Function, colour and depth code come out unchanged, code 0 included.
- R8: The sub-word position is the low 4 bits of the index of the selected surface. It is computed with that surface's own width.
- R9: While `rst` is high, and for the first two clocks after it, `out_valid` is low. A command that is in flight when reset arrives never appears.
- R10: Source and destination settings are independent. Changing one surface's settings does not alter the result for a command located in the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Command present this clock |
| in_func | input | 4 | Function code (0 no-op, 1 write, 2 masked write, 3 paste, 4 masked paste, 6 copy) |
| in_x | input | 12 | Pixel column |
| in_y | input | 12 | Pixel row |
| in_color | input | 8 | Colour value passed through |
| dst_base | input | 20 | Destination surface base byte address |
| dst_width | input | 16 | Destination raster width in pixels |
| dst_bpp | input | 4 | Destination depth code (depth minus one) |
| src_base | input | 20 | Source surface base byte address |
| src_width | input | 16 | Source raster width in pixels |
| src_bpp | input | 4 | Source depth code (depth minus one) |
| out_valid | output | 1 | Output command present |
| out_cmd | output | 40 | Packed output command |

## Verification
The bench targets the first pixel positions inside a word at each depth, where a wrong shift entry would put neighbouring pixels in the wrong word. It also runs the unlisted depth codes, which a design that decoded them would shift too far. It uses odd base addresses and an address that wraps past bit 19, which catch a missing alignment mask or carry handling done in the wrong order. Copy and paste commands are mixed while the two surfaces hold different settings, so that a swapped surface select or a mixed-up width shows up in both the address and the sub-word position. Settings change every clock and a reset lands on an in-flight command; a stage that fed on first-stage values or leaked a stale valid would be caught there.

// File: rtl/pxag_pkg.sv
package pxag_pkg;

    // Function code whose pixel lives in the source surface.
    localparam logic [3:0] FN_COPY = 4'd6;

    // Fixed depth-to-shift map: depth code holds depth minus one.
    function automatic logic [2:0] depth_shift(input logic [3:0] depth_code);
        case (depth_code)
            4'd0:    return 3'd4;
            4'd1:    return 3'd3;
            4'd3:    return 3'd2;
            4'd7:    return 3'd1;
            default: return 3'd0;
        endcase
    endfunction

    function automatic logic reads_source(input logic [3:0] fn);
        return fn == FN_COPY;
    endfunction

endpackage

// File: rtl/pxag_index_stage.sv
module pxag_index_stage #(
    parameter int COORD_W = 12,
    parameter int WIDTH_W = 16,
    parameter int ADDR_W  = 20,
    parameter int COLOR_W = 8,
    parameter int IDX_W   = COORD_W + WIDTH_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [3:0]         in_func,
    input  logic [COORD_W-1:0] in_x,
    input  logic [COORD_W-1:0] in_y,
    input  logic [COLOR_W-1:0] in_color,
    input  logic [ADDR_W-1:0]  dst_base,
    input  logic [WIDTH_W-1:0] dst_width,
    input  logic [3:0]         dst_bpp,
    input  logic [ADDR_W-1:0]  src_base,
    input  logic [WIDTH_W-1:0] src_width,
    input  logic [3:0]         src_bpp,
    output logic               s1_valid,
    output logic [3:0]         s1_func,
    output logic [COLOR_W-1:0] s1_color,
    output logic [3:0]         s1_bpp,
    output logic [ADDR_W-1:0]  s1_base,
    output logic [IDX_W-1:0]   s1_index
);
    import pxag_pkg::*;

    logic               use_src;
    logic [WIDTH_W-1:0] sel_width;
    logic [ADDR_W-1:0]  sel_base;
    logic [3:0]         sel_bpp;
    logic [IDX_W-1:0]   index_next;

    // Surface select and linear index (R1)
    always_comb begin
        use_src    = reads_source(in_func);
        sel_width  = use_src ? src_width : dst_width;
        sel_base   = use_src ? src_base  : dst_base;
        sel_bpp    = use_src ? src_bpp   : dst_bpp;
        index_next = IDX_W'(in_y) * IDX_W'(sel_width) + IDX_W'(in_x);
    end

    always_ff @(posedge clk) begin
        if (rst) s1_valid <= 1'b0;
        else     s1_valid <= in_valid;
    end

    always_ff @(posedge clk) begin
        s1_func  <= in_func;
        s1_color <= in_color;
        s1_bpp   <= sel_bpp;
        s1_base  <= sel_base;
        s1_index <= index_next;
    end

endmodule

// File: rtl/pxag_address_stage.sv
module pxag_address_stage #(
    parameter int ADDR_W  = 20,
    parameter int COLOR_W = 8,
    parameter int IDX_W   = 29,
    parameter int CMD_W   = ADDR_W + COLOR_W + 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               s1_valid,
    input  logic [3:0]         s1_func,
    input  logic [COLOR_W-1:0] s1_color,
    input  logic [3:0]         s1_bpp,
    input  logic [ADDR_W-1:0]  s1_base,
    input  logic [IDX_W-1:0]   s1_index,
    output logic               out_valid,
    output logic [CMD_W-1:0]   out_cmd
);
    import pxag_pkg::*;

    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(1);

    logic [2:0]        shamt;
    logic [ADDR_W-1:0] offset;
    logic [ADDR_W-1:0] word_addr;
    logic [3:0]        sub_pos;

    // Only registered first-stage values feed this stage (R3, R5, R8)
    always_comb begin
        shamt     = depth_shift(s1_bpp);
        offset    = ADDR_W'({s1_index, 1'b0} >> shamt);
        word_addr = (s1_base + offset) & ALIGN_MASK;
        sub_pos   = s1_index[3:0];
    end

    always_ff @(posedge clk) begin
        if (rst) out_valid <= 1'b0;
        else     out_valid <= s1_valid;
    end

    always_ff @(posedge clk) begin
        out_cmd <= {s1_func, s1_color, s1_bpp, sub_pos, word_addr};
    end

    // R2: emitted addresses are word aligned
    p_word_aligned_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_cmd[0] == 1'b0));

endmodule

// File: rtl/pixel_addr_pipe.sv
module pixel_addr_pipe #(
    parameter int COORD_W = 12,
    parameter int WIDTH_W = 16,
    parameter int ADDR_W  = 20,
    parameter int COLOR_W = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          in_valid,
    input  logic [3:0]                    in_func,
    input  logic [COORD_W-1:0]            in_x,
    input  logic [COORD_W-1:0]            in_y,
    input  logic [COLOR_W-1:0]            in_color,
    input  logic [ADDR_W-1:0]             dst_base,
    input  logic [WIDTH_W-1:0]            dst_width,
    input  logic [3:0]                    dst_bpp,
    input  logic [ADDR_W-1:0]             src_base,
    input  logic [WIDTH_W-1:0]            src_width,
    input  logic [3:0]                    src_bpp,
    output logic                          out_valid,
    output logic [ADDR_W+COLOR_W+11:0]    out_cmd
);
    localparam int IDX_W     = COORD_W + WIDTH_W + 1;
    localparam int CMD_W     = ADDR_W + COLOR_W + 12;
    localparam int COLOR_LSB = ADDR_W + 8;
    localparam int FUNC_LSB  = ADDR_W + 8 + COLOR_W;

    logic               s1_valid;
    logic [3:0]         s1_func;
    logic [COLOR_W-1:0] s1_color;
    logic [3:0]         s1_bpp;
    logic [ADDR_W-1:0]  s1_base;
    logic [IDX_W-1:0]   s1_index;

    pxag_index_stage #(
        .COORD_W(COORD_W), .WIDTH_W(WIDTH_W), .ADDR_W(ADDR_W),
        .COLOR_W(COLOR_W), .IDX_W(IDX_W)
    ) u_index (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_func(in_func), .in_x(in_x), .in_y(in_y),
        .in_color(in_color),
        .dst_base(dst_base), .dst_width(dst_width), .dst_bpp(dst_bpp),
        .src_base(src_base), .src_width(src_width), .src_bpp(src_bpp),
        .s1_valid(s1_valid), .s1_func(s1_func), .s1_color(s1_color),
        .s1_bpp(s1_bpp), .s1_base(s1_base), .s1_index(s1_index)
    );

    pxag_address_stage #(
        .ADDR_W(ADDR_W), .COLOR_W(COLOR_W), .IDX_W(IDX_W), .CMD_W(CMD_W)
    ) u_address (
        .clk(clk), .rst(rst),
        .s1_valid(s1_valid), .s1_func(s1_func), .s1_color(s1_color),
        .s1_bpp(s1_bpp), .s1_base(s1_base), .s1_index(s1_index),
        .out_valid(out_valid), .out_cmd(out_cmd)
    );

    // Edges since reset, saturating at 2, so $past never reaches into reset
    logic [1:0] warm;
    always_ff @(posedge clk) begin
        if (rst)               warm <= 2'd0;
        else if (warm != 2'd2) warm <= warm + 2'd1;
    end

    // R6: two-clock latency of the valid flag
    p_latency_r6: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd2) |-> (out_valid == $past(in_valid, 2)));

    // R7: function and colour emerge unchanged with their result
    p_func_carry_r7: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd2 && out_valid) |->
            (out_cmd[FUNC_LSB+3:FUNC_LSB] == $past(in_func, 2)));

    p_color_carry_r7: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd2 && out_valid) |->
            (out_cmd[COLOR_LSB+COLOR_W-1:COLOR_LSB] == $past(in_color, 2)));

    // R9: nothing emerges in the first clocks after reset
    p_reset_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd0) |-> !out_valid);

endmodule

// File: tb/pixel_addr_pipe_bench.sv
module pixel_addr_pipe_bench;

    localparam int COORD_W = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [3:0]  in_func = '0;
    logic [11:0] in_x = '0;
    logic [11:0] in_y = '0;
    logic [7:0]  in_color = '0;
    logic [19:0] dst_base = '0;
    logic [15:0] dst_width = '0;
    logic [3:0]  dst_bpp = '0;
    logic [19:0] src_base = '0;
    logic [15:0] src_width = '0;
    logic [3:0]  src_bpp = '0;
    logic        out_valid;
    logic [39:0] out_cmd;

    pixel_addr_pipe u_pixel_addr_pipe (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_func(in_func),
        .in_x(in_x), .in_y(in_y), .in_color(in_color),
        .dst_base(dst_base), .dst_width(dst_width), .dst_bpp(dst_bpp),
        .src_base(src_base), .src_width(src_width), .src_bpp(src_bpp),
        .out_valid(out_valid), .out_cmd(out_cmd)
    );

    always #2 clk = ~clk;   // 250 MHz

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [39:0] q_cmd[$];
    int          q_cyc[$];
    string       q_tag[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [39:0] model(input logic [3:0] f, input int x,
                                          input int y, input logic [7:0] c);
        logic [19:0] base;
        logic [15:0] w;
        logic [3:0]  bpp;
        longint      idx;
        longint      off;
        int          sh;
        logic [19:0] a;
        if (f == 4'd6) begin base = src_base; w = src_width; bpp = src_bpp; end
        else           begin base = dst_base; w = dst_width; bpp = dst_bpp; end
        idx = longint'(y) * longint'(w) + longint'(x);
        case (bpp)
            4'd0: sh = 4;
            4'd1: sh = 3;
            4'd3: sh = 2;
            4'd7: sh = 1;
            default: sh = 0;
        endcase
        off = (idx << 1) >> sh;
        a = base + off[19:0];
        a[0] = 1'b0;
        return {f, c, bpp, idx[3:0], a};
    endfunction

    task automatic issue(input logic [3:0] f, input int x, input int y,
                         input logic [7:0] c, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_func  = f;
        in_x     = COORD_W'(x);
        in_y     = COORD_W'(y);
        in_color = c;
        q_cmd.push_back(model(f, x, y, c));
        q_cyc.push_back(cyc + 2);
        q_tag.push_back(tag);
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && !done && out_valid) begin
            if (q_cmd.size() == 0) begin
                check(1'b0, "R9 R6 spurious output", {24'd0, out_cmd}, 64'd0);
            end else begin
                logic [39:0] e;
                int          ec;
                string       t;
                e  = q_cmd.pop_front();
                ec = q_cyc.pop_front();
                t  = q_tag.pop_front();
                check(out_cmd == e, t, {24'd0, out_cmd}, {24'd0, e});
                check(cyc == ec, "R6 latency", 64'(cyc), 64'(ec));
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        repeat (3) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R9 during reset", 64'(out_valid), 64'd0);
        end
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R9 after reset", 64'(out_valid), 64'd0);

        // R3 R8: 1 bpp destination
        dst_base = 20'h10000; dst_width = 16'd320; dst_bpp = 4'd0;
        src_base = 20'h70000; src_width = 16'd64;  src_bpp = 4'd15;
        issue(4'd1, 0, 0, 8'h11, "R3 R8 1bpp x0");
        issue(4'd1, 15, 0, 8'h12, "R3 R8 1bpp x15");
        issue(4'd1, 16, 0, 8'h13, "R3 R8 1bpp x16");
        issue(4'd1, 5, 3, 8'h14, "R3 R8 1bpp row3");
        // settings change every clock (R6)
        dst_bpp = 4'd1;
        issue(4'd1, 7, 2, 8'h21, "R3 R6 2bpp x7");
        issue(4'd1, 8, 2, 8'h22, "R3 R6 2bpp x8");
        dst_bpp = 4'd3;
        issue(4'd1, 3, 1, 8'h31, "R3 4bpp x3");
        issue(4'd1, 4, 1, 8'h32, "R3 4bpp x4");
        dst_bpp = 4'd7;
        issue(4'd1, 1, 9, 8'h41, "R3 8bpp x1");
        issue(4'd1, 2, 9, 8'h42, "R3 8bpp x2");
        dst_bpp = 4'd15;
        issue(4'd1, 1, 9, 8'h51, "R3 16bpp x1");
        idle(3);

        // R4: unlisted depth codes act as 16 bpp
        dst_bpp = 4'd5;
        issue(4'd1, 37, 11, 8'h61, "R4 code5");
        dst_bpp = 4'd12;
        issue(4'd1, 37, 11, 8'h62, "R4 code12");
        dst_bpp = 4'd2;
        issue(4'd2, 9, 4, 8'h63, "R4 code2");
        idle(2);

        // R2 R5: odd base, and wrap past bit 19
        dst_base = 20'h00101; dst_width = 16'd640; dst_bpp = 4'd15;
        issue(4'd1, 3, 2, 8'h71, "R2 R5 odd base 16bpp");
        dst_bpp = 4'd7;
        issue(4'd1, 3, 2, 8'h72, "R2 R5 odd base 8bpp");
        dst_base = 20'hFFF00; dst_width = 16'd4000; dst_bpp = 4'd15;
        issue(4'd1, 100, 4000, 8'h73, "R5 wrap");
        dst_base = 20'hFFFFF; dst_width = 16'd65535; dst_bpp = 4'd0;
        issue(4'd1, 4095, 4095, 8'h74, "R2 R5 max coords");
        idle(3);

        // R1 R10: copy located in source, others in destination
        dst_base = 20'h20000; dst_width = 16'd320; dst_bpp = 4'd7;
        src_base = 20'h40000; src_width = 16'd200; src_bpp = 4'd3;
        issue(4'd6, 13, 7, 8'h81, "R1 R8 copy from source");
        issue(4'd3, 13, 7, 8'h82, "R1 R8 paste into destination");
        src_width = 16'd999; src_base = 20'h55555;
        issue(4'd3, 13, 7, 8'h83, "R10 dest unaffected by source change");
        dst_width = 16'd17; dst_base = 20'h0AAAA;
        issue(4'd6, 13, 7, 8'h84, "R10 source unaffected by dest change");
        issue(4'd4, 6, 1, 8'h85, "R1 masked paste");
        idle(2);

        // R7: pass-through of function, colour, depth
        issue(4'd0, 1, 1, 8'hFF, "R7 nop code");
        issue(4'd2, 2, 2, 8'h00, "R7 masked write");
        issue(4'd15, 3, 3, 8'hA5, "R7 unknown func");
        issue(4'd6, 4, 4, 8'h5A, "R7 copy fields");
        idle(4);

        // R6: everything emerged
        check(q_cmd.size() == 0, "R6 drained", 64'(q_cmd.size()), 64'd0);

        // R9: in-flight command killed by reset
        @(negedge clk);
        in_valid = 1'b1; in_func = 4'd1; in_x = 12'd1; in_y = 12'd1;
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R9 in-flight dropped", 64'(out_valid), 64'd0);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R9 quiet after reset", 64'(out_valid), 64'd0);
        end

        // R6 R3: traffic resumes after reset
        dst_base = 20'h00000; dst_width = 16'd256; dst_bpp = 4'd1;
        issue(4'd1, 255, 255, 8'h91, "R6 R3 after reset");
        idle(4);
        check(q_cmd.size() == 0, "R6 final drain", 64'(q_cmd.size()), 64'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule